// File: doc/BRIEF.md
# Host-Side Serial DAC Frame Controller

This block lets a host write 16-bit words to up to four serial DAC devices. The devices share one serial clock line and one serial data line. Each device has its own active-low frame line, and all of them share an active-low load line. The host makes a request by giving a 2-bit device code and a data word. The controller then:

1. Lowers the frame line of the chosen device.
2. Sends the word as two 8-bit bursts. A programmable number of idle serial periods may sit between the two bursts, and the frame stays low across that gap.
3. Raises the frame again.
4. Pulses the load line if the update mode calls for it.

The serial clock idles low. Data changes on its rising edge, and the receiving device samples on its falling edge. A per-request option sends each byte least-significant bit first, for hosts whose shift hardware works that way. Frame selection goes through a registered 2-to-4 decoder. The decoder's enable is held inactive while a new device code is loaded, so a code change can never produce a glitch on a frame line.

In per-word update mode, every word is followed by a load pulse. In batch mode, only a word flagged as the last of a batch is followed by a load pulse.

Top module: `sdac_frame_ctrl`

## Requirements
- R1: After reset:
  - all four frame lines and the load line are high;
  - the serial clock and serial data are low;
  - busy is low and req_ready is high.
- R2: The serial clock idles low. Each serial period lasts DIV system clocks, split into a high half and a low half of DIV/2 cycles each. Serial data changes only in the cycle in which the clock rises, or while no frame is active.
- R3: Each byte burst has exactly eight falling clock edges, so a word has sixteen while its frame is low.
- R4: The frame goes low DIV/2 cycles before the first rising edge and stays low between the two bytes. It returns high DIV/2 cycles after the sixteenth falling edge.
- R5: With cfg_lsb_first = 0, the upper byte (bits 15..8) is sent first, and each byte goes out most significant bit first. With cfg_lsb_first = 1, the byte order stays the same but the bits within each byte go out least significant bit first.
- R6: Between the eighth falling edge and the next rising edge, the serial clock stays low for cfg_gap full serial periods plus one half period. A value of 0 gives a single half period.
- R7: After the frame rises, load_n is driven low for exactly one serial period, while all frames are high. This happens after every word when cfg_batch = 0. When cfg_batch = 1, it happens only after a word with req_last = 1.
- R8: Frame line number req_dev is the only one driven low for a request. At most one frame line is low at any time.
- R9: The device code held by the decoder only changes while the decoder enable is inactive and was inactive in the previous cycle.
- R10: req_ready is high only while idle, and a request is accepted when req_valid and req_ready are both high at a clock edge. busy is high from the cycle after acceptance until the load pulse and one further serial period with all frames high have passed. As a result, all frames have been high for at least DIV cycles before the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_dev | input | 2 | Target device code (0..3) |
| req_word | input | 16 | Word to send |
| req_last | input | 1 | Marks the final word of a batch |
| cfg_batch | input | 1 | 1: load pulse only after a last word; 0: after every word |
| cfg_lsb_first | input | 1 | 1: send each byte least significant bit first |
| cfg_gap | input | GAP_W | Idle serial periods between the two bytes |
| sclk | output | 1 | Shared serial clock |
| sdo | output | 1 | Shared serial data |
| frame_n | output | 4 | Active-low frame lines, one per device |
| load_n | output | 1 | Shared active-low load strobe |
| busy | output | 1 | Transfer or load sequence in progress |

## Verification
Two things can land on the same clock edge:
- the end of the first byte and the start of the second;
- the end of one word's rest period and the acceptance of the next request.

The first case is provoked with cfg_gap = 0. The edge that would end the eighth low half then has to raise the clock and present the first bit of the second byte in the same cycle. The second case is provoked by holding req_valid high while the controller is busy. The new request must be taken on exactly the edge on which req_ready first rises, with the new device's frame still blanked for a half period. Both cases are judged by a cycle-by-cycle behavioural model of all outputs and by shift-register models of the four receiving devices.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NDEV   = 4;
  localparam int CODE_W = $clog2(NDEV);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_FRM,
    ST_SHIFT,
    ST_GAP,
    ST_LOAD,
    ST_HOLD
  } seq_state_e;

  // mirror the bit order of one byte
  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  // byte as it must appear on the wire, first bit in the MSB position
  function automatic logic [BYTE_W-1:0] wire_byte(input logic [WORD_W-1:0] w,
                                                  input logic upper,
                                                  input logic lsb_first);
    logic [BYTE_W-1:0] b;
    b = upper ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    return lsb_first ? rev_byte(b) : b;
  endfunction

  // active-high one-hot of a device code
  function automatic logic [NDEV-1:0] code_onehot(input logic [CODE_W-1:0] c);
    return NDEV'(1) << c;
  endfunction

endpackage

// File: rtl/sdac_tick.sv
module sdac_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sdac_fdec.sv
module sdac_fdec
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_in,
  input  logic              en,
  output logic [NDEV-1:0]   frame_n
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       code_q <= '0;
    else if (code_we) code_q <= code_in;
  end

  assign frame_n = en ? ~code_onehot(code_q) : '1;

  // R8: never more than one device framed
  a_r8_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~frame_n));

  // R9: the code only moves while the decoder is blanked
  a_r9_code_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> (!en && !$past(en)));

endmodule

// File: rtl/sdac_seq.sv
module sdac_seq
  import sdac_pkg::*;
#(
  parameter int GAP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic              run,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_word,
  input  logic              req_last,
  input  logic              cfg_batch,
  input  logic              cfg_lsb_first,
  input  logic [GAP_W-1:0]  cfg_gap,
  output logic              code_we,
  output logic              fen,
  output logic              sclk,
  output logic              sdo,
  output logic              load_n,
  output logic              busy
);
  localparam int GW1 = GAP_W + 1;
  localparam int BI_W = $clog2(BYTE_W);

  seq_state_e        state;
  logic [WORD_W-1:0] word_q;
  logic              lsb_q;
  logic              load_q;
  logic [GAP_W-1:0]  gap_q;
  logic              byte_q;
  logic [BI_W:0]     hc;
  logic [GW1-1:0]    gc;
  logic              sclk_q, sdo_q, fen_q, load_n_q;

  logic [BYTE_W-1:0] hi_b, lo_b, cur_b;
  logic [BI_W-1:0]   nxt_k;
  logic              last_half;
  logic              gap_done;
  logic              accept;

  assign hi_b      = wire_byte(word_q, 1'b1, lsb_q);
  assign lo_b      = wire_byte(word_q, 1'b0, lsb_q);
  assign cur_b     = byte_q ? lo_b : hi_b;
  assign nxt_k     = hc[BI_W:1] + 1'b1;
  assign last_half = (hc == {(BI_W+1){1'b1}});
  assign gap_done  = (GW1'(gc + 1'b1) == {gap_q, 1'b0});

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign code_we   = accept;
  assign run       = (state != ST_IDLE);
  assign busy      = run;
  assign fen       = fen_q;
  assign sclk      = sclk_q;
  assign sdo       = sdo_q;
  assign load_n    = load_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word_q   <= '0;
      lsb_q    <= 1'b0;
      load_q   <= 1'b0;
      gap_q    <= '0;
      byte_q   <= 1'b0;
      hc       <= '0;
      gc       <= '0;
      sclk_q   <= 1'b0;
      sdo_q    <= 1'b0;
      fen_q    <= 1'b0;
      load_n_q <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          word_q <= req_word;
          lsb_q  <= cfg_lsb_first;
          gap_q  <= cfg_gap;
          load_q <= !cfg_batch || req_last;
          sdo_q  <= 1'b0;
          hc     <= '0;
          state  <= ST_SEL;
        end
        ST_SEL: if (tick) begin
          fen_q <= 1'b1;
          state <= ST_FRM;
        end
        ST_FRM: if (tick) begin
          byte_q <= 1'b0;
          hc     <= '0;
          sclk_q <= 1'b1;
          sdo_q  <= hi_b[BYTE_W-1];
          state  <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          hc <= hc + 1'b1;
          if (!hc[0]) begin
            sclk_q <= 1'b0;
          end else if (!last_half) begin
            sclk_q <= 1'b1;
            sdo_q  <= cur_b[BI_W'(BYTE_W-1) - nxt_k];
          end else if (!byte_q) begin
            if (gap_q == '0) begin
              byte_q <= 1'b1;
              sclk_q <= 1'b1;
              sdo_q  <= lo_b[BYTE_W-1];
            end else begin
              gc    <= '0;
              state <= ST_GAP;
            end
          end else begin
            fen_q <= 1'b0;
            sdo_q <= 1'b0;
            hc    <= '0;
            if (load_q) begin
              load_n_q <= 1'b0;
              state    <= ST_LOAD;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap_done) begin
            byte_q <= 1'b1;
            hc     <= '0;
            sclk_q <= 1'b1;
            sdo_q  <= lo_b[BYTE_W-1];
            state  <= ST_SHIFT;
          end else begin
            gc <= gc + 1'b1;
          end
        end
        ST_LOAD: if (tick) begin
          if (hc[0]) begin
            load_n_q <= 1'b1;
            hc       <= '0;
            state    <= ST_HOLD;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        ST_HOLD: if (tick) begin
          if (hc[0]) begin
            hc    <= '0;
            state <= ST_IDLE;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // falling-edge counter used only by the checks below
  logic       sclk_d;
  logic [4:0] fall_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      fall_cnt <= '0;
    end else begin
      sclk_d   <= sclk_q;
      fall_cnt <= fen_q ? fall_cnt + 5'(sclk_d & ~sclk_q) : '0;
    end
  end

  // R2: data moves with a rising clock or outside any frame
  a_r2_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> ($rose(sclk_q) || !fen_q));

  // R3: a frame ends after exactly sixteen falling edges
  a_r3_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fen_q) |-> (fall_cnt == 5'd16));

  // R4: the clock only runs inside an active frame
  a_r4_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> fen_q);

  // R7: the load strobe never overlaps a frame
  a_r7_load_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_q |-> !fen_q);

endmodule

// File: rtl/sdac_frame_ctrl.sv
module sdac_frame_ctrl
  import sdac_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int GAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_dev,
  input  logic [15:0]      req_word,
  input  logic             req_last,
  input  logic             cfg_batch,
  input  logic             cfg_lsb_first,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             sclk,
  output logic             sdo,
  output logic [3:0]       frame_n,
  output logic             load_n,
  output logic             busy
);
  localparam int DIV_E = (DIV < 4) ? 4 : DIV;
  localparam int HALF  = DIV_E / 2;
  localparam int HC_W  = $clog2(DIV_E + 1);

  logic tick, run, code_we, fen;

  sdac_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  sdac_seq #(.GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .req_valid(req_valid), .req_ready(req_ready), .req_word(req_word),
    .req_last(req_last), .cfg_batch(cfg_batch), .cfg_lsb_first(cfg_lsb_first),
    .cfg_gap(cfg_gap), .code_we(code_we), .fen(fen), .sclk(sclk), .sdo(sdo),
    .load_n(load_n), .busy(busy)
  );

  sdac_fdec u_fdec (
    .clk(clk), .rst_n(rst_n), .code_we(code_we), .code_in(req_dev),
    .en(fen), .frame_n(frame_n)
  );

  // cycles of continuous all-frames-high, saturating at the period
  logic [HC_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                     hi_cnt <= '0;
    else if (!(&frame_n))           hi_cnt <= '0;
    else if (hi_cnt != HC_W'(DIV_E)) hi_cnt <= hi_cnt + 1'b1;
  end

  // R10: a full serial period of rest precedes renewed readiness
  a_r10_frame_rest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (hi_cnt >= HC_W'(DIV_E)));

endmodule

// File: tb/test_sdac_frame_ctrl.sv
module test_sdac_frame_ctrl;

  localparam int DIV   = 8;
  localparam int HALF  = DIV / 2;
  localparam int GAP_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_dev = '0;
  logic [15:0] req_word = '0;
  logic req_last = 1'b0, cfg_batch = 1'b0, cfg_lsb_first = 1'b0;
  logic [GAP_W-1:0] cfg_gap = '0;
  logic req_ready, sclk, sdo, load_n, busy;
  logic [3:0] frame_n;

  always #5 clk = ~clk;

  sdac_frame_ctrl #(.DIV(DIV), .GAP_W(GAP_W)) i_sdac_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_word(req_word), .req_last(req_last),
    .cfg_batch(cfg_batch), .cfg_lsb_first(cfg_lsb_first), .cfg_gap(cfg_gap),
    .sclk(sclk), .sdo(sdo), .frame_n(frame_n), .load_n(load_n), .busy(busy)
  );

  typedef struct packed {
    logic       sclk;
    logic       sdo;
    logic       busy;
    logic       ready;
    logic       load_n;
    logic [3:0] frame_n;
  } exp_t;

  localparam exp_t IDLE_E = '{sclk: 1'b0, sdo: 1'b0, busy: 1'b0, ready: 1'b1,
                              load_n: 1'b1, frame_n: 4'hF};

  exp_t  q[$];
  exp_t  cur = IDLE_E;
  int    checks = 0, errors = 0;
  int    loads_exp = 0, loads_seen = 0, words_rx = 0;
  logic [15:0] exp_rx [4];
  logic [15:0] rx_sh [4];
  int    rx_cnt [4];
  logic  sclk_p = 1'b0, load_p = 1'b1;
  logic [3:0] frame_p = 4'hF;
  int    cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic void push_half(input exp_t e);
    for (int i = 0; i < HALF; i++) q.push_back(e);
  endfunction

  // behavioural expectation of one word transfer, by half serial period
  function automatic void build(input logic [15:0] w, input logic [1:0] d,
                                input logic lsb, input logic ld, input int gap);
    exp_t e;
    logic [7:0] b;
    logic [15:0] rx;
    e = '{sclk: 1'b0, sdo: 1'b0, busy: 1'b1, ready: 1'b0, load_n: 1'b1, frame_n: 4'hF};
    push_half(e);                         // decoder blanked
    e.frame_n = ~(4'b0001 << d);
    push_half(e);                         // frame set-up
    rx = '0;
    for (int by = 0; by < 2; by++) begin
      b = (by == 0) ? w[15:8] : w[7:0];
      for (int k = 0; k < 8; k++) begin
        e.sdo  = lsb ? b[k] : b[7-k];
        rx     = {rx[14:0], e.sdo};
        e.sclk = 1'b1; push_half(e);
        e.sclk = 1'b0; push_half(e);
      end
      if (by == 0)
        for (int g = 0; g < 2 * gap; g++) push_half(e);
    end
    e.sdo = 1'b0;
    e.frame_n = 4'hF;
    if (ld) begin
      e.load_n = 1'b0;
      push_half(e); push_half(e);
      e.load_n = 1'b1;
      loads_exp++;
    end
    push_half(e); push_half(e);
    exp_rx[d] = rx;
  endfunction

  // reference model advance
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      cur = IDLE_E;
    end else if (cur.ready && req_valid) begin
      build(req_word, req_dev, cfg_lsb_first, !cfg_batch || req_last, int'(cfg_gap));
      cur = q.pop_front();
    end else if (q.size() > 0) begin
      cur = q.pop_front();
    end else begin
      cur = IDLE_E;
    end
  end

  // compare and device models, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sclk == cur.sclk, "R2 R6 sclk", sclk, cur.sclk);
      chk(sdo == cur.sdo, "R5 sdo", sdo, cur.sdo);
      chk(frame_n == cur.frame_n, "R4 R8 R9 frame_n", frame_n, cur.frame_n);
      chk(load_n == cur.load_n, "R7 load_n", load_n, cur.load_n);
      chk(busy == cur.busy, "R10 busy", busy, cur.busy);
      chk(req_ready == cur.ready, "R10 req_ready", req_ready, cur.ready);
      for (int i = 0; i < 4; i++) begin
        if (sclk_p && !sclk && !frame_n[i]) begin
          rx_sh[i] = {rx_sh[i][14:0], sdo};
          rx_cnt[i]++;
        end
        if (!frame_p[i] && frame_n[i]) begin
          chk(rx_cnt[i] == 16, "R3 falls per frame", rx_cnt[i], 16);
          chk(rx_sh[i] == exp_rx[i], "R4 R5 device word", rx_sh[i], exp_rx[i]);
          words_rx++;
        end
        if (frame_p[i] && !frame_n[i]) begin
          rx_cnt[i] = 0;
          rx_sh[i] = '0;
        end
      end
      if (load_p && !load_n) loads_seen++;
    end
    sclk_p  = sclk;
    frame_p = frame_n;
    load_p  = load_n;
  end

  task automatic send(input logic [15:0] w, input logic [1:0] d, input logic lsb,
                      input logic batch, input logic last, input logic [2:0] gap);
    @(negedge clk);
    req_valid = 1'b1; req_word = w; req_dev = d; cfg_lsb_first = lsb;
    cfg_batch = batch; req_last = last; cfg_gap = gap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(frame_n == 4'hF, "R1 frame_n", frame_n, 4'hF);
    chk(load_n == 1'b1, "R1 load_n", load_n, 1);
    chk(sclk == 1'b0 && sdo == 1'b0, "R1 sclk sdo", {sclk, sdo}, 0);
    chk(busy == 1'b0 && req_ready == 1'b1, "R1 busy ready", {busy, req_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(16'hA5C3, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);   // R6 zero gap, R7 per-word
    wait_idle();
    send(16'h1234, 2'd3, 1'b1, 1'b0, 1'b0, 3'd2);   // R5 LSB-first bytes
    wait_idle();
    // R7 batch: only the flagged word loads
    send(16'h8001, 2'd1, 1'b0, 1'b1, 1'b0, 3'd1);
    send(16'h7FFE, 2'd2, 1'b0, 1'b1, 1'b0, 3'd0);
    send(16'hF00F, 2'd1, 1'b1, 1'b1, 1'b1, 3'd7);
    wait_idle();
    // R10 back-to-back, R9 code change across devices
    send(16'hFFFF, 2'd2, 1'b0, 1'b0, 1'b0, 3'd3);
    send(16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0);
    send(16'h5A5A, 2'd0, 1'b1, 1'b1, 1'b0, 3'd1);
    wait_idle();
    repeat (DIV) @(negedge clk);

    chk(loads_seen == loads_exp, "R7 load pulse count", loads_seen, loads_exp);
    chk(words_rx == 8, "R3 R8 words received", words_rx, 8);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule